// File: doc/BRIEF.md
# Shared Second-Level Translation Cache

This block sits behind the instruction-side and data-side first-level TLBs and serves their misses from a single 4-way, 256-set translation cache (1024 entries with the default parameters). Fetch misses enter a two-entry queue and data misses enter a four-entry queue. A round-robin arbiter drains the two queues one lookup at a time. A lookup that finds a matching valid entry refills the first-level TLB that asked, within a budget of four clock cycles. A lookup that misses is sent to an external page table walker. The walker's answer is written into the cache and forwarded to the requester.

Each entry is indexed by the low bits of the virtual page number. Its tag is made of the remaining page bits and the address-space identifier. The entry stores the physical page number and a large-page flag. When a set fills, a way is chosen first among the invalid ways and otherwise by a free-running two-bit counter. A one-cycle flush input invalidates every entry.

Top module: `l2x_cache`

## Requirements
- R1: After reset both miss inputs are ready, both refill valids are low and no walk request is pending.
- R2: Pages whose virtual page numbers share their low 8 bits fall in the same set. Up to four such pages (same ASID) stay resident together, because an invalid way is always filled before any valid one is replaced.
- R3: A lookup that hits, on an otherwise idle block, drives the refill valid of the requesting side (irefill_valid for fetch, drefill_valid for data) exactly 3 rising edges after the edge that accepted the miss. It carries the stored translation and issues no walk request.
- R4: A miss raises walk_req_valid with the page number, ASID and source (walk_req_src 0 = fetch, 1 = data). It holds them until walk_req_ready is seen high at a rising edge.
- R5: The walker response (walk_rsp_ppn, walk_rsp_big) is written into the cache and appears on the requester's refill port at the next rising edge. A later lookup of the same page hits.
- R6: A hit needs both the page number and the ASID to match. The same page under another ASID misses and is walked.
- R7: The fetch queue holds two pending misses. With two waiting and the lookup pipeline busy, imiss_ready is low.
- R8: The data queue holds four pending misses. With four waiting and the pipeline busy, dmiss_ready is low.
- R9: When both queues hold misses, service alternates between them, starting with fetch after reset.
- R10: A flush pulse invalidates every entry, so the next lookup of any page misses. A flush in the same cycle as a walker response still forwards that response to the requester, but the translation is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| imiss_valid | input | 1 | Fetch-side miss request |
| imiss_ready | output | 1 | Fetch queue has room |
| imiss_vpn | input | VPN_W | Fetch miss virtual page number |
| imiss_asid | input | ASID_W | Fetch miss ASID |
| dmiss_valid | input | 1 | Data-side miss request |
| dmiss_ready | output | 1 | Data queue has room |
| dmiss_vpn | input | VPN_W | Data miss virtual page number |
| dmiss_asid | input | ASID_W | Data miss ASID |
| walk_req_valid | output | 1 | Walk request pending |
| walk_req_ready | input | 1 | Walker accepts request |
| walk_req_vpn | output | VPN_W | Page to walk |
| walk_req_asid | output | ASID_W | ASID of the walk |
| walk_req_src | output | 1 | 0 fetch, 1 data |
| walk_rsp_valid | input | 1 | Walker result valid |
| walk_rsp_ppn | input | PPN_W | Walker physical page number |
| walk_rsp_big | input | 1 | Walker large-page flag |
| irefill_valid | output | 1 | Refill to fetch-side TLB |
| drefill_valid | output | 1 | Refill to data-side TLB |
| refill_vpn | output | VPN_W | Refilled virtual page number |
| refill_asid | output | ASID_W | Refilled ASID |
| refill_ppn | output | PPN_W | Refilled physical page number |
| refill_big | output | 1 | Refilled large-page flag |

## Verification
Flush and cache fill can land on the same edge, when a walker response arrives in the cycle the flush input is high. The bench's walker model raises flush on exactly the response cycle. The scoreboard then requires that the refill still carries the walked translation, and that a repeat lookup of the page produces a fresh walk. A scoreboard keyed per side also checks each refill against the translation function of the walker model, and checks the order of walks while both queues contend.

// File: rtl/l2x_pkg.sv
package l2x_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CMP, ST_WALK} l2x_state_e;
  localparam logic SRC_FETCH = 1'b0;
  localparam logic SRC_DATA  = 1'b1;
endpackage

// File: rtl/l2x_fifo.sv
module l2x_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = slot[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        slot[wp] <= din;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  // R7 R8
  depth_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
  // R7 R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/l2x_rr_arb.sv
module l2x_rr_arb (
  input  logic clk,
  input  logic rst,
  input  logic req_f,
  input  logic req_d,
  input  logic adv,
  output logic gnt_f,
  output logic gnt_d
);
  logic prio_d;

  assign gnt_f = req_f & (~req_d | ~prio_d);
  assign gnt_d = req_d & (~req_f | prio_d);

  always_ff @(posedge clk) begin
    if (rst) prio_d <= 1'b0;
    else if (adv && (gnt_f || gnt_d)) prio_d <= gnt_f;
  end

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({gnt_f, gnt_d}));
  // R9
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && req_f && req_d) |=> (!(req_f && req_d) || (gnt_f != $past(gnt_f))));
endmodule

// File: rtl/l2x_ways.sv
module l2x_ways #(
  parameter int SETS = 256,
  parameter int WAYS = 4,
  parameter int EW   = 41
) (
  input  logic                     clk,
  input  logic [$clog2(SETS)-1:0]  rd_set,
  output logic [WAYS*EW-1:0]       rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_set,
  input  logic [$clog2(WAYS)-1:0]  wr_way,
  input  logic [EW-1:0]            wr_data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [EW-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == w) mem[wr_set] <= wr_data;
      rd_data[w*EW +: EW] <= mem[rd_set];
    end
  end
endmodule

// File: rtl/l2x_cache.sv
module l2x_cache
  import l2x_pkg::*;
#(
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int FQ_DEPTH = 2,
  parameter int DQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              imiss_valid,
  output logic              imiss_ready,
  input  logic [VPN_W-1:0]  imiss_vpn,
  input  logic [ASID_W-1:0] imiss_asid,
  input  logic              dmiss_valid,
  output logic              dmiss_ready,
  input  logic [VPN_W-1:0]  dmiss_vpn,
  input  logic [ASID_W-1:0] dmiss_asid,
  output logic              walk_req_valid,
  input  logic              walk_req_ready,
  output logic [VPN_W-1:0]  walk_req_vpn,
  output logic [ASID_W-1:0] walk_req_asid,
  output logic              walk_req_src,
  input  logic              walk_rsp_valid,
  input  logic [PPN_W-1:0]  walk_rsp_ppn,
  input  logic              walk_rsp_big,
  output logic              irefill_valid,
  output logic              drefill_valid,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic [ASID_W-1:0] refill_asid,
  output logic [PPN_W-1:0]  refill_ppn,
  output logic              refill_big
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int QW    = VPN_W + ASID_W;
  localparam int EW    = 1 + PPN_W + ASID_W + TAG_W;

  l2x_state_e state;
  logic [QW-1:0] fq_dout, dq_dout;
  logic fq_full, fq_empty, dq_full, dq_empty;
  logic gnt_f, gnt_d, adv;
  logic [VPN_W-1:0]  r_vpn;
  logic [ASID_W-1:0] r_asid;
  logic              r_src;
  logic [WAY_W-1:0]  r_victim, victim, rnd;
  logic [WAYS*EW-1:0] rd_data;
  logic [WAYS-1:0]   vld [SETS];
  logic [WAYS-1:0]   set_vld;
  logic              hit, vic_found, fill, any_vld;
  logic [PPN_W-1:0]  hit_ppn;
  logic              hit_big;

  assign imiss_ready = ~fq_full;
  assign dmiss_ready = ~dq_full;
  assign adv = (state == ST_IDLE);

  l2x_fifo #(.DEPTH(FQ_DEPTH), .W(QW)) u_fq (
    .clk, .rst, .push(imiss_valid & ~fq_full), .din({imiss_vpn, imiss_asid}),
    .pop(adv & gnt_f), .dout(fq_dout), .full(fq_full), .empty(fq_empty));

  l2x_fifo #(.DEPTH(DQ_DEPTH), .W(QW)) u_dq (
    .clk, .rst, .push(dmiss_valid & ~dq_full), .din({dmiss_vpn, dmiss_asid}),
    .pop(adv & gnt_d), .dout(dq_dout), .full(dq_full), .empty(dq_empty));

  l2x_rr_arb u_arb (
    .clk, .rst, .req_f(~fq_empty), .req_d(~dq_empty), .adv, .gnt_f, .gnt_d);

  assign fill = (state == ST_WALK) && walk_rsp_valid && !walk_req_valid;

  l2x_ways #(.SETS(SETS), .WAYS(WAYS), .EW(EW)) u_ways (
    .clk, .rd_set(r_vpn[SET_W-1:0]), .rd_data,
    .wr_en(fill), .wr_set(r_vpn[SET_W-1:0]), .wr_way(r_victim),
    .wr_data({walk_rsp_big, walk_rsp_ppn, r_asid, r_vpn[VPN_W-1:SET_W]}));

  assign set_vld = vld[r_vpn[SET_W-1:0]];

  // tag compare across the ways and victim choice
  always_comb begin
    hit     = 1'b0;
    hit_ppn = '0;
    hit_big = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (set_vld[w] &&
          rd_data[w*EW +: TAG_W] == r_vpn[VPN_W-1:SET_W] &&
          rd_data[w*EW+TAG_W +: ASID_W] == r_asid) begin
        hit     = 1'b1;
        hit_ppn = rd_data[w*EW+TAG_W+ASID_W +: PPN_W];
        hit_big = rd_data[w*EW+EW-1];
      end
    end
    hit = hit & ~flush;
    victim    = rnd;
    vic_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vic_found && !set_vld[w]) begin
        victim    = WAY_W'(w);
        vic_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rnd <= '0;
    else     rnd <= rnd + 1'b1;
  end

  // valid bits kept in flops so a flush clears all of them in one cycle
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (fill) begin
      vld[r_vpn[SET_W-1:0]][r_victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      r_vpn          <= '0;
      r_asid         <= '0;
      r_src          <= SRC_FETCH;
      r_victim       <= '0;
      walk_req_valid <= 1'b0;
      irefill_valid  <= 1'b0;
      drefill_valid  <= 1'b0;
      refill_vpn     <= '0;
      refill_asid    <= '0;
      refill_ppn     <= '0;
      refill_big     <= 1'b0;
    end else begin
      irefill_valid <= 1'b0;
      drefill_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (gnt_f || gnt_d) begin
            {r_vpn, r_asid} <= gnt_f ? fq_dout : dq_dout;
            r_src <= gnt_f ? SRC_FETCH : SRC_DATA;
            state <= ST_READ;
          end
        end
        ST_READ: state <= ST_CMP;
        ST_CMP: begin
          r_victim <= victim;
          if (hit) begin
            irefill_valid <= (r_src == SRC_FETCH);
            drefill_valid <= (r_src == SRC_DATA);
            refill_vpn    <= r_vpn;
            refill_asid   <= r_asid;
            refill_ppn    <= hit_ppn;
            refill_big    <= hit_big;
            state         <= ST_IDLE;
          end else begin
            walk_req_valid <= 1'b1;
            state          <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_req_valid && walk_req_ready) walk_req_valid <= 1'b0;
          if (fill) begin
            irefill_valid <= (r_src == SRC_FETCH);
            drefill_valid <= (r_src == SRC_DATA);
            refill_vpn    <= r_vpn;
            refill_asid   <= r_asid;
            refill_ppn    <= walk_rsp_ppn;
            refill_big    <= walk_rsp_big;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign walk_req_vpn  = r_vpn;
  assign walk_req_asid = r_asid;
  assign walk_req_src  = r_src;

  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld[s]);
  end

  // R3
  hit_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP && hit) |=> (irefill_valid || drefill_valid) && !walk_req_valid);
  // R4
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && !walk_req_ready) |=> walk_req_valid && $stable(walk_req_vpn) && $stable(walk_req_asid));
  // R5
  fill_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    fill |=> (irefill_valid || drefill_valid) && refill_ppn == $past(walk_rsp_ppn));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst) flush |=> !any_vld);
  // R3
  refill_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({irefill_valid, drefill_valid}));
endmodule

// File: tb/sim_l2x_cache.sv
module sim_l2x_cache;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int ASID_W = 8;

  typedef struct {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              lat_chk;
    int                acc;
  } exp_t;

  logic clk = 0, rst = 1, flush_t = 0, flush_w = 0, flush;
  logic imiss_valid = 0, dmiss_valid = 0, walk_req_ready = 0, walk_rsp_valid = 0, walk_rsp_big = 0;
  logic [VPN_W-1:0] imiss_vpn = '0, dmiss_vpn = '0;
  logic [ASID_W-1:0] imiss_asid = '0, dmiss_asid = '0;
  logic [PPN_W-1:0] walk_rsp_ppn = '0;
  logic imiss_ready, dmiss_ready, walk_req_valid, walk_req_src, irefill_valid, drefill_valid, refill_big;
  logic [VPN_W-1:0] walk_req_vpn, refill_vpn;
  logic [ASID_W-1:0] walk_req_asid, refill_asid;
  logic [PPN_W-1:0] refill_ppn;

  assign flush = flush_t | flush_w;

  l2x_cache u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, n_chk = 0, n_bad = 0, pending = 0, walk_cnt = 0;
  logic hold = 0, flush_on_rsp = 0, done = 0;
  exp_t exp_i[$], exp_d[$];
  logic walk_log[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PPN_W-1:0] xl(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    return v * 20'd3 + {12'd0, a};
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // walker model
  initial begin
    forever begin
      @(negedge clk);
      if (walk_req_valid && !hold) begin
        logic [VPN_W-1:0] v;
        logic [ASID_W-1:0] a;
        v = walk_req_vpn; a = walk_req_asid;
        walk_log.push_back(walk_req_src);
        walk_cnt++;
        walk_req_ready = 1;
        @(negedge clk);
        walk_req_ready = 0;
        repeat (2) @(negedge clk);
        walk_rsp_valid = 1;
        walk_rsp_ppn = xl(v, a);
        walk_rsp_big = v[0];
        flush_w = flush_on_rsp;
        @(negedge clk);
        walk_rsp_valid = 0;
        flush_w = 0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (irefill_valid || drefill_valid) begin
        exp_t e;
        if ((irefill_valid && exp_i.size() == 0) || (drefill_valid && exp_d.size() == 0)) begin
          chk(0, "R3 unexpected refill", refill_vpn, 0);
        end else begin
          e = irefill_valid ? exp_i.pop_front() : exp_d.pop_front();
          pending--;
          chk(refill_vpn == e.vpn && refill_asid == e.asid, "R5 refill page", refill_vpn, e.vpn);
          chk(refill_ppn == xl(e.vpn, e.asid), "R5 refill ppn", refill_ppn, xl(e.vpn, e.asid));
          chk(refill_big == e.vpn[0], "R5 refill size", refill_big, e.vpn[0]);
          if (e.lat_chk) chk(cyc - e.acc == 3, "R3 hit latency", cyc - e.acc, 3);
        end
      end
    end
  end

  task automatic send(input logic src, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic lat);
    exp_t e;
    @(negedge clk);
    if (src) begin dmiss_valid = 1; dmiss_vpn = v; dmiss_asid = a; end
    else     begin imiss_valid = 1; imiss_vpn = v; imiss_asid = a; end
    while (!(src ? dmiss_ready : imiss_ready)) @(negedge clk);
    @(posedge clk); #1;
    e.vpn = v; e.asid = a; e.lat_chk = lat; e.acc = cyc;
    if (src) exp_d.push_back(e); else exp_i.push_back(e);
    pending++;
    @(negedge clk);
    imiss_valid = 0; dmiss_valid = 0;
  endtask

  task automatic run_one(input logic src, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                         input logic exp_hit, input string tag);
    int w0;
    w0 = walk_cnt;
    send(src, v, a, exp_hit);
    wait (pending == 0);
    repeat (2) @(negedge clk);
    chk((walk_cnt - w0) == (exp_hit ? 0 : 1), tag, walk_cnt - w0, exp_hit ? 0 : 1);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic exp_order [7];
    do_reset();
    @(negedge clk);
    // R1
    chk(imiss_ready && dmiss_ready, "R1 readies", {imiss_ready, dmiss_ready}, 3);
    chk(!irefill_valid && !drefill_valid, "R1 refill idle", {irefill_valid, drefill_valid}, 0);
    chk(!walk_req_valid, "R1 no walk", walk_req_valid, 0);

    // R4 R5: first miss, then hits from both sides
    run_one(0, 20'h12345, 8'd5, 0, "R4 first lookup walks");
    run_one(0, 20'h12345, 8'd5, 1, "R5 retained after fill");
    run_one(1, 20'h12345, 8'd5, 1, "R3 data side hit");
    // R6
    run_one(1, 20'h12345, 8'd6, 0, "R6 asid mismatch walks");
    run_one(0, 20'h12345, 8'd6, 1, "R6 new asid retained");

    // R2: four pages in one set
    for (int k = 1; k <= 4; k++) run_one(k[0], VPN_W'(k * 32'h1000 + 32'h40), 8'd1, 0, "R2 set fill walks");
    for (int k = 1; k <= 4; k++) run_one(~k[0], VPN_W'(k * 32'h1000 + 32'h40), 8'd1, 1, "R2 four ways resident");

    // R10: flush
    @(negedge clk); flush_t = 1; @(negedge clk); flush_t = 0;
    run_one(0, 20'h12345, 8'd5, 0, "R10 flush invalidates");
    run_one(1, 20'h02040, 8'd1, 0, "R10 flush invalidates set");
    // R10: flush concurrent with fill
    flush_on_rsp = 1;
    run_one(1, 20'h0ABCD, 8'd2, 0, "R10 flush with fill walks");
    flush_on_rsp = 0;
    run_one(1, 20'h0ABCD, 8'd2, 0, "R10 fill dropped by flush");

    // R7 R8 R9: contention from both queues
    do_reset();
    walk_log.delete();
    hold = 1;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      @(negedge clk);
      imiss_valid = (k < 3); imiss_vpn = VPN_W'(32'h30000 + k); imiss_asid = 8'd3;
      dmiss_valid = 1;       dmiss_vpn = VPN_W'(32'h50000 + k); dmiss_asid = 8'd4;
      if (k < 3) begin
        e.vpn = imiss_vpn; e.asid = 8'd3; e.lat_chk = 0; e.acc = 0;
        exp_i.push_back(e); pending++;
      end
      e.vpn = dmiss_vpn; e.asid = 8'd4; e.lat_chk = 0; e.acc = 0;
      exp_d.push_back(e); pending++;
    end
    @(negedge clk);
    imiss_valid = 0; dmiss_valid = 0;
    @(negedge clk);
    chk(!imiss_ready, "R7 fetch queue full at two", imiss_ready, 0);
    chk(!dmiss_ready, "R8 data queue full at four", dmiss_ready, 0);
    hold = 0;
    wait (pending == 0);
    repeat (2) @(negedge clk);
    exp_order = '{0, 1, 0, 1, 0, 1, 1};
    chk(walk_log.size() == 7, "R9 walk count", walk_log.size(), 7);
    for (int k = 0; k < 7; k++) begin
      if (k < walk_log.size())
        chk(walk_log[k] == exp_order[k], "R9 alternation order", walk_log[k], exp_order[k]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule